// File: doc/BRIEF.md
# Dual-Class Interrupt Controller

This block gathers level-style request lines from twenty source positions and steers each one to a normal interrupt output, a fast interrupt output, both, or neither. Each class has its own enable mask. A register bus reads three views per class:

- a raw view, common to both classes, showing which sources are requesting;
- the class's enable mask;
- a masked status view.

Each mask is changed through a pair of write-only ports. One port sets enable bits and the other clears them. A write of zero bits to either port leaves the mask unchanged.

Requests are not latched. A raw bit follows its source line and falls only when the peripheral withdraws the request. Three bit positions have fixed roles:

- Position 1 carries the software request from a dedicated pin. No enable write can affect it.
- Position 15 is reserved.
- Position 0 is not a source. In the fast class it reports the OR of all other fast status bits.

One shared select register names a source index. A probe register then reports that source's raw, enable and status bits for both classes.

Top module: `icn_top`

## Requirements
- R1: The raw view at address 0 and at address 4 reads the same value. That value is the source lines sampled one clock earlier, with bit 1 taken from `swi_i` and bits 0 and 15 forced to 0.
- R2: A write to the enable-set port sets each enable bit written as 1 and leaves bits written as 0 unchanged. The set port is address 1 for the normal class and address 5 for the fast class.
- R3: A write to the clear port clears each enable bit written as 1 and leaves the others unchanged. The clear port is address 2 for the normal class and address 6 for the fast class.
- R4: Each status view (address 3 normal, address 7 fast) has bits [19:1] equal to raw AND that class's enable mask.
- R5: Fast status bit 0 is the OR of fast status bits [19:1]. Normal status bit 0 always reads 0.
- R6: Enable writes never set bit 1 in either mask. The software request therefore appears in the raw view only.
- R7: Bit 15 is reserved. It reads 0 in raw, enable and status, and no write can enable it.
- R8: `irq_o` is the OR of normal status and `fiq_o` is the OR of fast status. Each output changes one clock after its status changes.
- R9: A source enabled in both classes drives both outputs high together.
- R10: Writes to the raw and status addresses change no register.
- R11: The select register (address 8) holds a 5-bit index. The probe register (address 9) returns the indexed source's bits in this order: raw in bit 0, normal enable in bit 1, fast enable in bit 2, normal status in bit 3 and fast status in bit 4. An index of 20 or more reads 0.
- R12: After reset both masks, the raw view, the select register and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 20 | Level request lines by position |
| swi_i | input | 1 | Software request, shown at position 1 |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Normal-class interrupt |
| fiq_o | output | 1 | Fast-class interrupt |

## Verification
The bench drives request patterns against masks that overlap in different ways:

- A source enabled in one class only shows that the two paths are separate.
- A source enabled in both classes shows that both outputs rise together.
- An all-ones enable write shows that the locked positions 0, 1 and 15 are filtered out.

When the requests move to new positions while the masks stay fixed, the bench checks that status follows the raw view and is not latched. Probe reads at an enabled source, at the software position and at an out-of-range index show that the select path reports per-source state.

// File: rtl/icn_pkg.sv
package icn_pkg;
    localparam int NSRC     = 20;
    localparam int AW       = 4;
    localparam int DW       = 32;
    localparam int SWI_POS  = 1;
    localparam int RSV_POS  = 15;
    localparam int NREG     = 10;
    localparam int SELW     = $clog2(NSRC);

    typedef enum logic [AW-1:0] {
        A_IRQ_RAW  = 4'd0,
        A_IRQ_SET  = 4'd1,
        A_IRQ_CLR  = 4'd2,
        A_IRQ_STA  = 4'd3,
        A_FIQ_RAW  = 4'd4,
        A_FIQ_SET  = 4'd5,
        A_FIQ_CLR  = 4'd6,
        A_FIQ_STA  = 4'd7,
        A_SEL      = 4'd8,
        A_PROBE    = 4'd9
    } icn_addr_e;

    localparam int CLASS_STRIDE = 4;
endpackage

// File: rtl/icn_wr_dec.sv
module icn_wr_dec #(
    parameter int AW   = 4,
    parameter int NREG = 10
) (
    input  logic [AW-1:0]   addr_i,
    input  logic            we_i,
    output logic [NREG-1:0] stb_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_stb
        assign stb_o[i] = we_i && (addr_i == AW'(i));
    end
endmodule

// File: rtl/icn_class_path.sv
module icn_class_path #(
    parameter int NSRC    = 20,
    parameter bit AGG     = 1'b0,
    parameter int SWI_POS = 1,
    parameter int RSV_POS = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_i,
    input  logic            set_we_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] sta_o,
    output logic            hit_o
);
    localparam logic [NSRC-1:0] ONE    = {{(NSRC-1){1'b0}}, 1'b1};
    localparam logic [NSRC-1:0] LOCKED = ONE | (ONE << SWI_POS) | (ONE << RSV_POS);

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic            hit;
    } path_st_t;

    path_st_t st_d, st_q;
    logic [NSRC-1:0] base;
    logic [NSRC-1:0] sta;

    assign base = raw_i & st_q.en;

    if (AGG) begin : g_agg
        assign sta = {base[NSRC-1:1], |base[NSRC-1:1]};
    end else begin : g_plain
        assign sta = {base[NSRC-1:1], 1'b0};
    end

    always_comb begin
        st_d = st_q;
        if (set_we_i) begin
            st_d.en = st_d.en | (wdata_i & ~LOCKED);
        end
        if (clr_we_i) begin
            st_d.en = st_d.en & ~wdata_i;
        end
        st_d.hit = |sta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign sta_o = sta;
    assign hit_o = st_q.hit;

    p_locked_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o & LOCKED) == '0);
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i && !clr_we_i) |=> ((en_o & $past(wdata_i & ~LOCKED)) == $past(wdata_i & ~LOCKED)));
    p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i && !clr_we_i) |=> ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((en_o & $past(wdata_i)) == '0));
    p_sta_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_o[NSRC-1:1] & ~raw_i[NSRC-1:1]) == '0);
    p_out_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_o == $past(|sta_o)));
endmodule

// File: rtl/icn_top.sv
module icn_top
    import icn_pkg::*;
#(
    parameter int NSRC_P = NSRC,
    parameter int DW_P   = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC_P-1:0] src_i,
    input  logic              swi_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DW_P-1:0]   bus_wdata_i,
    output logic [DW_P-1:0]   bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int SW = $clog2(NSRC_P);
    localparam logic [NSRC_P-1:0] ONE = {{(NSRC_P-1){1'b0}}, 1'b1};
    localparam logic [NSRC_P-1:0] RAW_DROP = ONE | (ONE << SWI_POS) | (ONE << RSV_POS);

    typedef struct packed {
        logic [NSRC_P-1:0] raw;
        logic [SW-1:0]     sel;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [NREG-1:0]   wstb;
    logic [NSRC_P-1:0] en_w  [2];
    logic [NSRC_P-1:0] sta_w [2];
    logic [1:0]        hit_w;
    logic [4:0]        probe;

    icn_wr_dec #(.AW(AW), .NREG(NREG)) u_dec (
        .addr_i (bus_addr_i),
        .we_i   (bus_we_i),
        .stb_o  (wstb)
    );

    for (genvar c = 0; c < 2; c++) begin : g_cls
        localparam int BASE = c * CLASS_STRIDE;
        icn_class_path #(
            .NSRC    (NSRC_P),
            .AGG     (c == 1),
            .SWI_POS (SWI_POS),
            .RSV_POS (RSV_POS)
        ) u_path (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (st_q.raw),
            .set_we_i (wstb[BASE + 1]),
            .clr_we_i (wstb[BASE + 2]),
            .wdata_i  (bus_wdata_i[NSRC_P-1:0]),
            .en_o     (en_w[c]),
            .sta_o    (sta_w[c]),
            .hit_o    (hit_w[c])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.raw = src_i & ~RAW_DROP;
        st_d.raw[SWI_POS] = swi_i;
        if (wstb[A_SEL]) begin
            st_d.sel = bus_wdata_i[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        probe = '0;
        for (int i = 0; i < NSRC_P; i++) begin
            if (st_q.sel == SW'(i)) begin
                probe = {sta_w[1][i], sta_w[0][i], en_w[1][i], en_w[0][i], st_q.raw[i]};
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_IRQ_RAW, A_FIQ_RAW: bus_rdata_o[NSRC_P-1:0] = st_q.raw;
            A_IRQ_SET:            bus_rdata_o[NSRC_P-1:0] = en_w[0];
            A_FIQ_SET:            bus_rdata_o[NSRC_P-1:0] = en_w[1];
            A_IRQ_STA:            bus_rdata_o[NSRC_P-1:0] = sta_w[0];
            A_FIQ_STA:            bus_rdata_o[NSRC_P-1:0] = sta_w[1];
            A_SEL:                bus_rdata_o[SW-1:0]     = st_q.sel;
            A_PROBE:              bus_rdata_o[4:0]        = probe;
            default:              bus_rdata_o = '0;
        endcase
    end

    assign irq_o = hit_w[0];
    assign fiq_o = hit_w[1];

    p_raw_rsv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.raw[RSV_POS] && !st_q.raw[0]);
    p_raw_swi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.raw[SWI_POS] == $past(swi_i)));
    p_both_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.raw & en_w[0] & en_w[1]) != '0) |=> (irq_o && fiq_o));
    p_fiq_agg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sta_w[1][0] == (sta_w[1][NSRC_P-1:1] != '0));
endmodule

// File: tb/sim_icn_top.sv
module sim_icn_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src = '0;
    logic        swi = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [3:0] IRAW = 4'd0, ISET = 4'd1, ICLR = 4'd2, ISTA = 4'd3;
    localparam logic [3:0] FRAW = 4'd4, FSET = 4'd5, FCLR = 4'd6, FSTA = 4'd7;
    localparam logic [3:0] SEL = 4'd8, PRB = 4'd9;

    typedef struct {
        bit          pins;
        logic [3:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    icn_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .swi_i(swi),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    initial begin
        forever begin
            @(mon_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.pins ? {30'b0, fiq, irq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.pins = 1'b0; it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        addr = a;
        #1;
        ->mon_ev;
        #1;
    endtask

    task automatic exp_pins(input logic [1:0] e, input string tag);
        item_t it;
        it.pins = 1'b1; it.a = '0; it.exp = {30'b0, e}; it.tag = tag;
        sb.push_back(it);
        #1;
        ->mon_ev;
        #1;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        exp_rd(IRAW, 32'h0, "R12 raw");
        exp_rd(ISET, 32'h0, "R12 irq enable");
        exp_rd(FSET, 32'h0, "R12 fiq enable");
        exp_rd(SEL,  32'h0, "R12 select");
        exp_pins(2'b00, "R12 pins");
        rst_n = 1'b1;
        settle();

        // sources at 0, 2 and 15 with the software pin high
        @(negedge clk);
        src = 20'h08005; swi = 1'b1;
        settle();
        exp_rd(IRAW, 32'h6, "R1 R7 raw via irq");
        exp_rd(FRAW, 32'h6, "R1 raw via fiq");
        exp_rd(ISTA, 32'h0, "R4 irq status unmasked");
        exp_pins(2'b00, "R4 nothing enabled");

        wr(ISET, 32'hFFFFF);
        exp_rd(ISET, 32'hF7FFC, "R2 R6 R7 irq enable all");
        exp_rd(ISTA, 32'h4, "R4 R5 irq status");
        @(negedge clk);
        exp_pins(2'b01, "R8 irq only");

        wr(FSET, 32'h4);
        exp_rd(FSTA, 32'h5, "R5 fiq agg bit0");
        exp_pins(2'b01, "R8 fiq not yet");
        @(negedge clk);
        exp_pins(2'b11, "R9 both classes");

        wr(ICLR, 32'h6);
        exp_rd(ISET, 32'hF7FF8, "R3 irq clear bit2");
        wr(ISET, 32'h0);
        exp_rd(ISET, 32'hF7FF8, "R2 zero write keeps");
        wr(FCLR, 32'h2);
        exp_rd(FSET, 32'h4, "R6 clear bit1 no effect");
        @(negedge clk);
        exp_pins(2'b10, "R8 irq dropped");

        wr(FSTA, 32'hFFFFF);
        wr(IRAW, 32'hFFFFF);
        wr(ISTA, 32'hFFFFF);
        exp_rd(FSTA, 32'h5, "R10 fiq status");
        exp_rd(FSET, 32'h4, "R10 fiq enable");
        exp_rd(ISET, 32'hF7FF8, "R10 irq enable");
        exp_rd(IRAW, 32'h6, "R10 raw");

        @(negedge clk);
        src = 20'h80400;
        settle();
        exp_rd(IRAW, 32'h80402, "R1 new raw");
        exp_rd(ISTA, 32'h80400, "R4 irq status follows");
        exp_rd(FSTA, 32'h0, "R4 R5 fiq status empty");
        exp_pins(2'b01, "R8 pins after move");

        wr(SEL, 32'd10);
        exp_rd(SEL, 32'd10, "R11 select readback");
        exp_rd(PRB, 32'hB, "R11 probe src10");
        wr(SEL, 32'd1);
        exp_rd(PRB, 32'h1, "R11 R6 probe swi");
        wr(SEL, 32'd25);
        exp_rd(SEL, 32'd25, "R11 select 25");
        exp_rd(PRB, 32'h0, "R11 probe out of range");

        wr(ICLR, 32'hFFFFF);
        wr(FSET, 32'h88000);
        exp_rd(FSET, 32'h80004, "R7 fiq rsv not enabled");
        exp_rd(FSTA, 32'h80001, "R5 fiq agg bit19");
        @(negedge clk);
        exp_pins(2'b10, "R8 fiq only");

        @(negedge clk);
        src = '0; swi = 1'b0;
        settle();
        exp_rd(FRAW, 32'h0, "R1 raw cleared");
        exp_pins(2'b00, "R8 R4 all quiet");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule